// File: doc/BRIEF.md
# Time-Multiplexed Neuron Control Engine

This block evaluates one two-input artificial neuron with a single shared multiplier and a single shared adder. A central state machine sequences the work. A start pulse opens an evaluation. The block then accepts the input values one at a time, each with a one-cycle strobe. Each input is multiplied by the weight that matches its arrival order, and the product is added to a running sum. After the last input the bias is added. The biased sum is handed to an external activation unit through a request/done handshake, and the value that unit returns becomes the result.

All arithmetic is signed 8-bit fixed point with 5 fractional bits (Q2.5), and it wraps on overflow. The last product, the running sum without bias and the biased sum each stay in a register driven to an output, so software or a debug path can observe every intermediate step. Weights and bias are plain inputs that are read when they are needed. A network of several layers can therefore be emulated by running the block again and again with new weights, feeding earlier results back in as inputs.

Top module: `neuron_engine`

## Requirements
- R1: While reset is high and after it is released: busy, done, act_req, result, mul_q, acc_q and biased_q are all 0.
- R2: A start pulse while not busy clears acc_q to 0, raises busy and clears done, all visible on the cycle after the pulse.
- R3: A start pulse while busy is ignored: the evaluation in progress continues and acc_q is not cleared.
- R4: Exactly NUM_INPUTS (default 2) inputs are accepted per evaluation. Input k, counted from 0 in arrival order, is multiplied by the weight at bits [8k+7:8k] of the weights port. An in_valid strobe that arrives while the engine is not waiting for an input is ignored.
- R5: The product is the full 16-bit signed product of input and weight, arithmetically shifted right by 5, with its low 8 bits kept. mul_q holds the last product.
- R6: Each product is added to acc_q with 8-bit wrap-around. No saturation is applied.
- R7: The bias is added only after all inputs have been accumulated. biased_q = acc_q + bias, wrapping at 8 bits, and acc_q keeps the sum without bias.
- R8: After the biased sum is formed, act_req is a one-cycle pulse with act_arg equal to biased_q. The next act_done pulse latches act_value into result. An act_done pulse that arrives before a request has been issued is ignored.
- R9: busy is high from the start pulse until the result is written. done is set together with the result and cleared by the next accepted start. busy and done are never high at the same time.
- R10: Only one arithmetic step (multiply, accumulate or bias add) is dispatched per cycle.
- R11: Back-to-back evaluations with new weights, bias and inputs each produce a result that depends only on their own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that opens an evaluation |
| in_valid | input | 1 | One-cycle strobe qualifying in_data |
| in_data | input | 8 | Input value, Q2.5 |
| weights | input | 16 | Weight k at bits [8k+7:8k], Q2.5 |
| bias | input | 8 | Bias, Q2.5 |
| act_req | output | 1 | One-cycle request to the activation unit |
| act_arg | output | 8 | Biased sum offered to the activation unit |
| act_done | input | 1 | Activation unit reports act_value valid |
| act_value | input | 8 | Activation output, Q2.5 |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Result available |
| result | output | 8 | Neuron output |
| mul_q | output | 8 | Last multiplier product |
| acc_q | output | 8 | Accumulated sum without bias |
| biased_q | output | 8 | Accumulated sum with bias |

## Verification
The bench covers products that overflow the 8-bit word. Examples are -4.0 times -4.0 and 127 times 127 in raw units. A multiplier that saturates, or that truncates before shifting, returns a different low byte than expected. It also covers sums that wrap past +127, which would expose a saturating adder. A stray input strobe sent while the multiply is still in progress checks that a design which latches it does not take the wrong operand. A start pulse sent in the middle of an evaluation checks that the running sum is not wiped. A premature act_done pulse checks that done is not raised early. Randomized back-to-back runs with changing weights and random activation latency catch any state carried over from the previous evaluation or a weight selected from the wrong slot.

// File: rtl/neu_pkg.sv
package neu_pkg;

    localparam int NEU_DW  = 8;
    localparam int NEU_FW  = 5;
    localparam int NEU_NIN = 2;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_IN  = 3'd1,
        ST_MUL      = 3'd2,
        ST_ACC      = 3'd3,
        ST_BIAS     = 3'd4,
        ST_ACT_REQ  = 3'd5,
        ST_ACT_WAIT = 3'd6
    } neu_state_e;

    // Dispatch strobes from the sequencer to the datapath.
    typedef struct packed {
        logic clr;   // open evaluation: clear running sum
        logic cap;   // capture incoming operand
        logic mul;   // shared multiplier writes product register
        logic acc;   // shared adder: sum + product
        logic bias;  // shared adder: sum + bias
        logic req;   // request to activation unit
        logic fin;   // activation value accepted
    } neu_ctl_t;

endpackage

// File: rtl/neu_mul.sv
module neu_mul #(
    parameter int DW = neu_pkg::NEU_DW,
    parameter int FW = neu_pkg::NEU_FW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] p
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shifted;

    always_comb begin
        full    = PW'($signed(a)) * PW'($signed(b));
        shifted = full >>> FW;
        p       = DW'(shifted);
    end
endmodule

// File: rtl/neu_add.sv
module neu_add #(
    parameter int DW = neu_pkg::NEU_DW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] s
);
    // Two's complement wrap: carry out is discarded.
    always_comb s = a + b;
endmodule

// File: rtl/neu_fsm.sv
module neu_fsm
    import neu_pkg::*;
#(
    parameter int NIN = neu_pkg::NEU_NIN,
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           in_valid,
    input  logic           act_done,
    output neu_ctl_t       ctl,
    output logic [IW-1:0]  idx,
    output logic           busy
);
    neu_state_e state_q, state_d;
    logic [IW-1:0] idx_d;

    localparam logic [IW-1:0] LAST_IDX = IW'(NIN - 1);

    always_comb begin
        state_d = state_q;
        idx_d   = idx;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.clr = 1'b1;
                    idx_d   = '0;
                    state_d = ST_WAIT_IN;
                end
            end
            ST_WAIT_IN: begin
                if (in_valid) begin
                    ctl.cap = 1'b1;
                    state_d = ST_MUL;
                end
            end
            ST_MUL: begin
                ctl.mul = 1'b1;
                state_d = ST_ACC;
            end
            ST_ACC: begin
                ctl.acc = 1'b1;
                if (idx == LAST_IDX) begin
                    idx_d   = '0;
                    state_d = ST_BIAS;
                end else begin
                    idx_d   = idx + 1'b1;
                    state_d = ST_WAIT_IN;
                end
            end
            ST_BIAS: begin
                ctl.bias = 1'b1;
                state_d  = ST_ACT_REQ;
            end
            ST_ACT_REQ: begin
                ctl.req = 1'b1;
                state_d = ST_ACT_WAIT;
            end
            ST_ACT_WAIT: begin
                if (act_done) begin
                    ctl.fin = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx     <= '0;
        end else begin
            state_q <= state_d;
            idx     <= idx_d;
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R10: one arithmetic step at a time on the shared units
    a_r10_one_dispatch: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.mul, ctl.acc, ctl.bias}));

    // R7: bias step only directly after the last accumulate
    a_r7_bias_after_last: assert property (@(posedge clk) disable iff (rst)
        ctl.bias |-> ($past(ctl.acc) && $past(idx) == LAST_IDX));

    // R3: a start while busy does not end the evaluation
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !(state_q == ST_ACT_WAIT && act_done)) |=> busy);

    // R4: input capture only happens from the waiting state
    a_r4_cap_when_waiting: assert property (@(posedge clk) disable iff (rst)
        ctl.cap |=> (state_q == ST_MUL));
endmodule

// File: rtl/neuron_engine.sv
module neuron_engine
    import neu_pkg::*;
#(
    parameter int DW  = neu_pkg::NEU_DW,
    parameter int FW  = neu_pkg::NEU_FW,
    parameter int NIN = neu_pkg::NEU_NIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    input  logic [DW-1:0]     in_data,
    input  logic [NIN*DW-1:0] weights,
    input  logic [DW-1:0]     bias,
    output logic              act_req,
    output logic [DW-1:0]     act_arg,
    input  logic              act_done,
    input  logic [DW-1:0]     act_value,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     result,
    output logic [DW-1:0]     mul_q,
    output logic [DW-1:0]     acc_q,
    output logic [DW-1:0]     biased_q
);
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1;

    neu_ctl_t      ctl;
    logic [IW-1:0] idx;
    logic [DW-1:0] x_q;
    logic [DW-1:0] w_sel;
    logic [DW-1:0] prod;
    logic [DW-1:0] add_b;
    logic [DW-1:0] add_s;

    neu_fsm #(.NIN(NIN)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .in_valid (in_valid),
        .act_done (act_done),
        .ctl      (ctl),
        .idx      (idx),
        .busy     (busy)
    );

    // Weight slot selected by arrival order of the current input.
    always_comb w_sel = weights[idx*DW +: DW];

    neu_mul #(.DW(DW), .FW(FW)) u_mul (
        .a (x_q),
        .b (w_sel),
        .p (prod)
    );

    // Shared adder: second operand is product or bias depending on step.
    always_comb add_b = ctl.bias ? bias : mul_q;

    neu_add #(.DW(DW)) u_add (
        .a (acc_q),
        .b (add_b),
        .s (add_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q      <= '0;
            mul_q    <= '0;
            acc_q    <= '0;
            biased_q <= '0;
            result   <= '0;
            done     <= 1'b0;
        end else begin
            if (ctl.clr)  begin
                acc_q <= '0;
                done  <= 1'b0;
            end
            if (ctl.cap)  x_q      <= in_data;
            if (ctl.mul)  mul_q    <= prod;
            if (ctl.acc)  acc_q    <= add_s;
            if (ctl.bias) biased_q <= add_s;
            if (ctl.fin) begin
                result <= act_value;
                done   <= 1'b1;
            end
        end
    end

    assign act_req = ctl.req;
    assign act_arg = biased_q;

    // R2: accepted start clears sum, raises busy, clears done
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && acc_q == '0));

    // R9: busy and done never together
    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R9: done rises only on an accepted activation value
    a_r9_done_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(act_done));

    // R8: request is a single-cycle pulse
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
        act_req |=> !act_req);

    // R3: sum untouched by start while busy outside the accumulate step
    a_r3_sum_kept: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !ctl.acc) |=> $stable(acc_q));
endmodule

// File: tb/neuron_engine_tb.sv
module neuron_engine_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        in_valid;
    logic [7:0]  in_data;
    logic [15:0] weights;
    logic [7:0]  bias;
    logic        act_req;
    logic [7:0]  act_arg;
    logic        act_done;
    logic [7:0]  act_value;
    logic        busy, done;
    logic [7:0]  result, mul_q, acc_q, biased_q;

    logic        resp_done = 1'b0;
    logic [7:0]  resp_val  = '0;
    logic        glitch_done = 1'b0;
    logic        resp_pend = 1'b0;
    int          resp_cnt  = 0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign act_done  = resp_done | glitch_done;
    assign act_value = glitch_done ? 8'h55 : resp_val;

    neuron_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_data(in_data), .weights(weights), .bias(bias),
        .act_req(act_req), .act_arg(act_arg), .act_done(act_done),
        .act_value(act_value), .busy(busy), .done(done), .result(result),
        .mul_q(mul_q), .acc_q(acc_q), .biased_q(biased_q)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic signed [15:0] f;
        f = 16'($signed(a)) * 16'($signed(b));
        f = f >>> 5;
        return f[7:0];
    endfunction

    // Bench activation: hard clamp to +-1.0 (raw +-32).
    function automatic logic [7:0] m_act(input logic [7:0] v);
        if ($signed(v) > 8'sd32)  return 8'd32;
        if ($signed(v) < -8'sd32) return 8'hE0;
        return v;
    endfunction

    // Activation responder with random latency.
    always @(negedge clk) begin
        resp_done <= 1'b0;
        if (resp_pend) begin
            if (resp_cnt == 0) begin
                resp_done <= 1'b1;
                resp_val  <= m_act(act_arg);
                resp_pend <= 1'b0;
            end else begin
                resp_cnt <= resp_cnt - 1;
            end
        end else if (act_req) begin
            resp_pend <= 1'b1;
            resp_cnt  <= int'($urandom % 3);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_in(input logic [7:0] v, input bit glitch);
        @(negedge clk);
        in_valid = 1'b1; in_data = v;
        @(negedge clk);
        if (glitch) begin
            in_data = ~v;          // arrives during multiply: must be ignored (R4)
        end else begin
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_eval(input logic [7:0] x0, input logic [7:0] x1,
                            input logic [7:0] w0, input logic [7:0] w1,
                            input logic [7:0] b, input bit glitch, input bit mid_start);
        logic [7:0] p0, p1, s, sb;
        p0 = m_mul(x0, w0);
        p1 = m_mul(x1, w1);
        s  = p0 + p1;
        sb = s + b;
        weights = {w1, w0};
        bias    = b;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", {7'd0, busy}, 8'd1);
        chk("R2 done cleared", {7'd0, done}, 8'd0);
        chk("R2 sum cleared", acc_q, 8'd0);
        send_in(x0, glitch);
        chk("R6 first accumulate", acc_q, p0);
        if (mid_start) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R3 sum kept on busy start", acc_q, p0);
            chk("R3 still busy", {7'd0, busy}, 8'd1);
        end
        send_in(x1, 1'b0);
        wait_done();
        chk("R5 last product", mul_q, p1);
        chk("R6 sum without bias", acc_q, s);
        chk("R7 biased sum", biased_q, sb);
        chk("R8 result", result, m_act(sb));
        chk("R9 done set", {7'd0, done}, 8'd1);
        chk("R9 busy cleared", {7'd0, busy}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_data = '0;
        weights = '0; bias = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {7'd0, busy}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", {7'd0, busy}, 8'd0);
        chk("R1 done", {7'd0, done}, 8'd0);
        chk("R1 act_req", {7'd0, act_req}, 8'd0);
        chk("R1 result", result, 8'd0);
        chk("R1 mul_q", mul_q, 8'd0);
        chk("R1 acc_q", acc_q, 8'd0);
        chk("R1 biased_q", biased_q, 8'd0);

        // R5 corner: -4.0 * -4.0 wraps to 0; 127*127 raw gives 0xF8
        run_eval(8'h80, 8'h7F, 8'h80, 8'h7F, 8'h00, 1'b0, 1'b0);
        // R6 wrap: 3.0*1.0 + 3.0*1.0 = 192 raw -> wraps negative
        run_eval(8'h60, 8'h60, 8'h20, 8'h20, 8'h10, 1'b0, 1'b0);
        // R4 stray strobe during multiply
        run_eval(8'h11, 8'hF0, 8'h25, 8'h3A, 8'hF8, 1'b1, 1'b0);
        // R3 start mid evaluation
        run_eval(8'h20, 8'h10, 8'h30, 8'hD0, 8'h04, 1'b0, 1'b1);

        // R8 premature act_done is ignored
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        glitch_done = 1'b1;
        @(negedge clk); glitch_done = 1'b0;
        chk("R8 early act_done: done low", {7'd0, done}, 8'd0);
        chk("R8 early act_done: busy high", {7'd0, busy}, 8'd1);
        send_in(8'h20, 1'b0);
        send_in(8'h20, 1'b0);
        wait_done();
        chk("R8 result after early act_done", result, m_act(8'h00 + m_mul(8'h20, 8'h30) + m_mul(8'h20, 8'hD0) + 8'h04));

        // R11 random back-to-back evaluations, new weights each time
        for (int i = 0; i < 40; i++) begin
            run_eval(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                     8'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule